// File: doc/BRIEF.md
# Nonvolatile Byte Store Access Controller

This block connects a small processor core to a 256-byte nonvolatile data array that lives in an address space of its own, apart from the main data memory. Software reaches it through three registers in the I/O space: an address register, a data register and a control register. A location is read by loading the address and setting a read strobe. The byte is copied into the data register, and instruction issue is frozen for four clock cycles. A location is written by loading the address and data and setting a master-enable bit. The write strobe must then follow within a short window. The write freezes issue for two cycles and then runs on its own timer, while a busy flag tells software when the next byte may start.

The array is modelled as a plain register file with a write latency set by a parameter. The write address and data are captured when the strobe is accepted, so software can reload both registers while the write is still in progress. The controller drives the stall to the core directly. The core is expected to issue no I/O access while the stall is high.

Top module: `nvmAccessCtrl`

## Requirements
- R1: After reset the address, data and control registers read 0x00, the stall output is low, and every array location reads 0xFF.
- R2: A write with select 0 loads the address register and a write with select 1 loads the data register; both read back the written byte through the same select.
- R3: Writing the control register with bit 0 set, while the busy bit (bit 3) is clear, copies the array byte at the current address into the data register and holds the stall output high for exactly 4 cycles, starting in the cycle after the write.
- R4: Control bit 0 reads 1 during the 4 stall cycles of a read and reads 0 once they end.
- R5: Writing the control register with bit 1 set, while the master-enable bit (bit 2) reads 1 and busy reads 0, starts a write, holds the stall high for exactly 2 cycles, and control bit 1 reads 1 during those cycles.
- R6: Setting control bit 2 makes it read 1 for 4 cycles, after which it clears by itself. A write strobe issued in any of those 4 cycles is accepted. A write strobe issued after they end has no effect.
- R7: A write strobe issued while the master-enable bit reads 0 causes no stall, no busy period and no change to the array.
- R8: An accepted write keeps busy (control bit 3) at 1 for exactly WR_LATENCY cycles (16 by default). The array location then holds the data byte, at the address that was set when the strobe was given, even if either register changes later.
- R9: While busy reads 1, read and write strobes are ignored: no stall, no change to the data register, and the array keeps its contents.
- R10: The master-enable bit reads 0 in the cycle after a write is accepted.
- R11: Select 3 reads 0x00, and control bits 7 to 4 always read 0. Writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioSel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 unused |
| ioWrEn | input | 1 | Register write strobe for the selected register |
| ioWrData | input | 8 | Write data from the core |
| ioRdData | output | 8 | Combinational read data of the selected register |
| cpuStall | output | 1 | Freezes instruction issue in the core |

## Verification
The checker assumes that the core issues no register write while cpuStall is high. Under that assumption the length of a stall run is bounded by the read stall. The bench keeps to this by waiting on the stall output after every strobe before it drives the next access. The bench also reads back every location after its write has finished. The checker therefore treats a data byte as visible only after busy falls. All register reads are sampled half a cycle after the edge that updated them.

// File: rtl/nvmAccessPkg.sv
package nvmAccessPkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } ioSel_e;

  // control register bit positions (software decodes these)
  localparam int BIT_RD   = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_ARM  = 2;
  localparam int BIT_BUSY = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic loadData;
    logic fetchByte;
    logic startWrite;
    logic commitWrite;
  } dpStrobe_t;

  // status flags shown in the control register
  typedef struct packed {
    logic busy;
    logic armed;
    logic wrActive;
    logic rdActive;
  } ctlStatus_t;

endpackage

// File: rtl/nvmAccessCtl.sv
module nvmAccessCtl
  import nvmAccessPkg::*;
#(
  parameter int READ_STALL  = 4,
  parameter int WRITE_STALL = 2,
  parameter int ARM_WINDOW  = 4,
  parameter int WR_LATENCY  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] ioSel,
  input  logic       ioWrEn,
  input  logic [2:0] ctrlBits,
  output dpStrobe_t  strb,
  output ctlStatus_t ctlStatus,
  output logic       cpuStall
);

  localparam int STALL_MAX = (READ_STALL > WRITE_STALL) ? READ_STALL : WRITE_STALL;
  localparam int STALL_W   = $clog2(STALL_MAX + 1);
  localparam int ARM_W     = $clog2(ARM_WINDOW + 1);
  localparam int BUSY_W    = $clog2(WR_LATENCY + 1);

  ioSel_e            selE;
  logic [STALL_W-1:0] stallCnt;
  logic               stallIsRead;
  logic [ARM_W-1:0]   armCnt;
  logic [BUSY_W-1:0]  busyCnt;

  logic ctrlWr;
  logic busyNow;
  logic armedNow;
  logic acceptWr;
  logic acceptRd;
  logic armReq;

  assign selE = ioSel_e'(ioSel);

  // accept decisions
  always_comb begin
    ctrlWr   = ioWrEn && (selE == SEL_CTRL);
    busyNow  = (busyCnt != '0);
    armedNow = (armCnt != '0);
    acceptWr = ctrlWr && ctrlBits[BIT_WR] && armedNow && !busyNow;
    acceptRd = ctrlWr && ctrlBits[BIT_RD] && !busyNow && !acceptWr;
    armReq   = ctrlWr && ctrlBits[BIT_ARM] && !acceptWr;
  end

  // strobes towards the datapath
  always_comb begin
    strb.loadAddr    = ioWrEn && (selE == SEL_ADDR);
    strb.loadData    = ioWrEn && (selE == SEL_DATA);
    strb.fetchByte   = acceptRd;
    strb.startWrite  = acceptWr;
    strb.commitWrite = (busyCnt == BUSY_W'(1));
  end

  // stall timer; direction picks the length
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt    <= '0;
      stallIsRead <= 1'b0;
    end else if (acceptWr) begin
      stallCnt    <= STALL_W'(WRITE_STALL);
      stallIsRead <= 1'b0;
    end else if (acceptRd) begin
      stallCnt    <= STALL_W'(READ_STALL);
      stallIsRead <= 1'b1;
    end else if (stallCnt != '0) begin
      stallCnt <= stallCnt - STALL_W'(1);
    end
  end

  // master-enable window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armCnt <= '0;
    end else if (acceptWr) begin
      armCnt <= '0;
    end else if (armReq) begin
      armCnt <= ARM_W'(ARM_WINDOW);
    end else if (armCnt != '0) begin
      armCnt <= armCnt - ARM_W'(1);
    end
  end

  // self-timed write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (acceptWr) begin
      busyCnt <= BUSY_W'(WR_LATENCY);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - BUSY_W'(1);
    end
  end

  always_comb begin
    cpuStall           = (stallCnt != '0);
    ctlStatus.rdActive = cpuStall && stallIsRead;
    ctlStatus.wrActive = cpuStall && !stallIsRead;
    ctlStatus.armed    = armedNow;
    ctlStatus.busy     = busyNow;
  end

endmodule

// File: rtl/nvmAccessDp.sv
module nvmAccessDp
  import nvmAccessPkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 8,
  parameter logic [7:0]  ERASED = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        ioSel,
  input  logic [DATA_W-1:0] ioWrData,
  input  dpStrobe_t         strb,
  input  ctlStatus_t        ctlStatus,
  output logic [DATA_W-1:0] ioRdData
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int STAT_W  = $bits(ctlStatus_t);
  localparam int PAD_W   = DATA_W - STAT_W;

  ioSel_e            selE;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;
  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] ctrlView;

  assign selE = ioSel_e'(ioSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (strb.loadAddr) begin
      addrReg <= ioWrData[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strb.fetchByte) begin
      dataReg <= cells[addrReg];
    end else if (strb.loadData) begin
      dataReg <= ioWrData;
    end
  end

  // write operands are frozen at the accepted strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendData <= '0;
    end else if (strb.startWrite) begin
      pendAddr <= addrReg;
      pendData <= dataReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= DATA_W'(ERASED);
      end
    end else if (strb.commitWrite) begin
      cells[pendAddr] <= pendData;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign ctrlView = {{PAD_W{1'b0}}, ctlStatus};
    end else begin : g_noPad
      assign ctrlView = ctlStatus[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    case (selE)
      SEL_ADDR: ioRdData = DATA_W'(addrReg);
      SEL_DATA: ioRdData = dataReg;
      SEL_CTRL: ioRdData = ctrlView;
      default:  ioRdData = '0;
    endcase
  end

endmodule

// File: rtl/nvmAccessCtrl.sv
module nvmAccessCtrl
  import nvmAccessPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int READ_STALL  = 4,
  parameter int WRITE_STALL = 2,
  parameter int ARM_WINDOW  = 4,
  parameter int WR_LATENCY  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        ioSel,
  input  logic              ioWrEn,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  output logic              cpuStall
);

  dpStrobe_t  strb;
  ctlStatus_t ctlStatus;

  nvmAccessCtl #(
    .READ_STALL (READ_STALL),
    .WRITE_STALL(WRITE_STALL),
    .ARM_WINDOW (ARM_WINDOW),
    .WR_LATENCY (WR_LATENCY)
  ) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .ioSel    (ioSel),
    .ioWrEn   (ioWrEn),
    .ctrlBits (ioWrData[2:0]),
    .strb     (strb),
    .ctlStatus(ctlStatus),
    .cpuStall (cpuStall)
  );

  nvmAccessDp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ioSel    (ioSel),
    .ioWrData (ioWrData),
    .strb     (strb),
    .ctlStatus(ctlStatus),
    .ioRdData (ioRdData)
  );

endmodule

// File: rtl/nvmAccessCtrlChk.sv
module nvmAccessCtrlChk
  import nvmAccessPkg::*;
#(
  parameter int READ_STALL = 4,
  parameter int WR_LATENCY = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       cpuStall,
  input dpStrobe_t  strb,
  input ctlStatus_t ctlStatus
);

  int stallRun;
  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallRun <= 0;
      busyRun  <= 0;
    end else begin
      stallRun <= cpuStall ? stallRun + 1 : 0;
      busyRun  <= ctlStatus.busy ? busyRun + 1 : 0;
    end
  end

  p_fetch_stalls_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetchByte |=> (cpuStall && ctlStatus.rdActive));

  p_stall_bounded_r3: assert property (@(posedge clk) disable iff (!rstN)
    stallRun <= READ_STALL);

  p_rd_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctlStatus.rdActive |-> cpuStall);

  p_write_stalls_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.startWrite |=> (cpuStall && ctlStatus.wrActive && ctlStatus.busy));

  p_write_needs_arm_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.startWrite |-> ctlStatus.armed);

  p_busy_bounded_r8: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= WR_LATENCY);

  p_commit_ends_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWrite |=> !ctlStatus.busy);

  p_idle_while_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctlStatus.busy |-> (!strb.startWrite && !strb.fetchByte));

  p_arm_drops_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.startWrite |=> !ctlStatus.armed);

endmodule

bind nvmAccessCtrl nvmAccessCtrlChk #(
  .READ_STALL(READ_STALL),
  .WR_LATENCY(WR_LATENCY)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cpuStall (cpuStall),
  .strb     (strb),
  .ctlStatus(ctlStatus)
);

// File: tb/nvmAccessCtrl_tb_top.sv
module nvmAccessCtrl_tb_top;

  localparam int LAT = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] ioSel = 2'd0;
  logic       ioWrEn = 1'b0;
  logic [7:0] ioWrData = 8'd0;
  logic [7:0] ioRdData;
  logic       cpuStall;

  int total = 0;
  int bad = 0;
  logic [7:0] model [256];

  always #2.5 clk = ~clk;

  nvmAccessCtrl #(.WR_LATENCY(LAT)) dut_i (
    .clk(clk), .rstN(rstN), .ioSel(ioSel), .ioWrEn(ioWrEn),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .cpuStall(cpuStall)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic ioWrite(logic [1:0] sel, logic [7:0] d);
    ioSel = sel; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic readReg(logic [1:0] sel, output logic [7:0] v);
    ioSel = sel;
    #0.5;
    v = ioRdData;
  endtask

  task automatic watch(output int stallN, output int busyN, output int rdN, output int wrN);
    logic [7:0] c;
    stallN = 0; busyN = 0; rdN = 0; wrN = 0;
    for (int i = 0; i < 200; i++) begin
      readReg(2'd2, c);
      if (!cpuStall && !c[3]) break;
      stallN += int'(cpuStall);
      busyN  += int'(c[3]);
      rdN    += int'(c[0]);
      wrN    += int'(c[1]);
      @(negedge clk);
    end
  endtask

  task automatic fetch(int a, output logic [7:0] v, output int stallN, output int rdN);
    int b, w;
    ioWrite(2'd0, 8'(a));
    ioWrite(2'd2, 8'h01);
    watch(stallN, b, rdN, w);
    readReg(2'd1, v);
  endtask

  task automatic store(int a, logic [7:0] d, output int stallN, output int busyN,
                       output int wrN, output logic armAfter);
    logic [7:0] c;
    int r;
    ioWrite(2'd0, 8'(a));
    ioWrite(2'd1, d);
    ioWrite(2'd2, 8'h04);
    ioWrite(2'd2, 8'h02);
    readReg(2'd2, c);
    armAfter = c[2];
    watch(stallN, busyN, r, wrN);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, c;
    int sN, bN, rN, wN;
    logic armAfter;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readReg(2'd0, v); chk("R1 addr", v, 0);
    readReg(2'd1, v); chk("R1 data", v, 0);
    readReg(2'd2, v); chk("R1 ctrl", v, 0);
    chk("R1 stall", int'(cpuStall), 0);
    for (int a = 0; a < 256; a++) begin
      model[a] = 8'hFF;
      fetch(a, v, sN, rN);
      chk("R1 erased", v, 255);
    end

    // R2 / R11 register access
    ioWrite(2'd0, 8'hA5); readReg(2'd0, v); chk("R2 addr", v, 8'hA5);
    ioWrite(2'd1, 8'h3C); readReg(2'd1, v); chk("R2 data", v, 8'h3C);
    ioWrite(2'd3, 8'h77); readReg(2'd3, v); chk("R11 sel3", v, 0);
    ioWrite(2'd2, 8'hF0); readReg(2'd2, v); chk("R11 ctrl high", v, 0);
    chk("R11 no stall", int'(cpuStall), 0);

    // R5 R8 R10 write sweep
    for (int a = 0; a < 256; a++) begin
      store(a, pat(a), sN, bN, wN, armAfter);
      model[a] = pat(a);
      chk("R5 write stall", sN, 2);
      chk("R5 wr flag", wN, 2);
      chk("R8 busy length", bN, LAT);
      chk("R10 arm cleared", int'(armAfter), 0);
    end

    // R3 R4 read sweep
    for (int a = 0; a < 256; a++) begin
      fetch(a, v, sN, rN);
      chk("R3 read data", v, model[a]);
      chk("R3 read stall", sN, 4);
      chk("R4 rd flag", rN, 4);
      readReg(2'd2, c);
      chk("R4 rd flag clear", int'(c[0]), 0);
    end

    // R7 unarmed strobe
    ioWrite(2'd0, 8'd7);
    ioWrite(2'd1, 8'h00);
    ioWrite(2'd2, 8'h02);
    watch(sN, bN, rN, wN);
    chk("R7 no stall", sN, 0);
    chk("R7 no busy", bN, 0);
    fetch(7, v, sN, rN);
    chk("R7 array kept", v, model[7]);

    // R6 arm window sweep
    for (int k = 0; k <= 5; k++) begin
      ioWrite(2'd0, 8'(16 + k));
      ioWrite(2'd1, 8'(128 + k));
      ioWrite(2'd2, 8'h04);
      repeat (k) @(negedge clk);
      readReg(2'd2, c);
      chk("R6 arm bit", int'(c[2]), (k <= 3) ? 1 : 0);
      ioWrite(2'd2, 8'h02);
      watch(sN, bN, rN, wN);
      chk("R6 window stall", sN, (k <= 3) ? 2 : 0);
      chk("R6 window busy", bN, (k <= 3) ? LAT : 0);
      if (k <= 3) model[16 + k] = 8'(128 + k);
      repeat (5) @(negedge clk);
      fetch(16 + k, v, sN, rN);
      chk("R6 window array", v, model[16 + k]);
    end

    // R8 R9 strobes during busy, captured operands
    ioWrite(2'd0, 8'h20);
    ioWrite(2'd1, 8'h55);
    ioWrite(2'd2, 8'h04);
    ioWrite(2'd2, 8'h02);
    model[32] = 8'h55;
    repeat (3) @(negedge clk);
    ioWrite(2'd0, 8'h21);
    ioWrite(2'd1, 8'h66);
    ioWrite(2'd2, 8'h01);
    chk("R9 read ignored stall", int'(cpuStall), 0);
    readReg(2'd2, c);
    chk("R9 rd flag low", int'(c[0]), 0);
    chk("R8 still busy", int'(c[3]), 1);
    readReg(2'd1, v);
    chk("R9 data unchanged", v, 8'h66);
    ioWrite(2'd2, 8'h04);
    ioWrite(2'd2, 8'h02);
    chk("R9 write ignored stall", int'(cpuStall), 0);
    watch(sN, bN, rN, wN);
    chk("R9 no extra stall", sN, 0);
    repeat (6) @(negedge clk);
    fetch(32, v, sN, rN);
    chk("R8 captured operands", v, 8'h55);
    fetch(33, v, sN, rN);
    chk("R9 array kept", v, model[33]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule